// File: doc/BRIEF.md
# Vectored Dual-Output Interrupt Controller

This block collects up to 32 interrupt sources and presents them to a processor as two separate request lines: a normal request and a critical request. Software programs each source as edge or level sensitive, enables it, and chooses whether it feeds the normal or the critical line. All of this goes through a simple word-addressed register bus, where offsets 0 to 8 hold the controller's registers.

Pending sources are latched in a status register. Software can clear status bits and set them through separate offsets. Clearing a bit whose source is level sensitive and still asserted does not remove it, because the controller puts that bit back. A build option adds a vector unit. While a critical source is pending, the vector unit gives an address equal to a programmable base plus 512 times the index of the first pending critical source. A direction bit in the configuration decides whether the scan starts at the lowest or the highest status bit.

Top module: `crit_irq_ctrl`

## Requirements
- R1: Input line n (0..31) drives status bit 31-n.
- R2: A source whose trigger bit is 1 is edge sensitive. A rising input sets its status bit, and the bit stays set after the input falls until software clears it.
- R3: A source whose trigger bit is 0 is level sensitive. A rising input sets its status bit and a falling input clears it, one clock after the change is sampled.
- R4: A write to offset 0 clears every status bit that has a 1 in the write data. Any bit whose level-sensitive input is currently high stays set.
- R5: A write to offset 1 ORs the write data into status. Reads at offset 0 and offset 1 both return status.
- R6: A read at offset 6 returns status AND enable (offset 2). Writes to offsets 6 and 7 change no register.
- R7: The normal output is high when status AND enable AND NOT critical-select (offset 3) is nonzero. The critical output is high when status AND enable AND critical-select is nonzero. Both follow a register write by one clock.
- R8: With vectors built in and a critical source pending, offset 7 reads (offset 8 value with bits 1:0 cleared) + 512*k. When offset 8 bit 0 is 0, k is the lowest pending critical bit position. When bit 0 is 1, k is 31 minus the highest pending critical bit position.
- R9: Offset 7 reads 0 when no critical source is pending. A write to offset 8 stores the data with bit 1 forced to 0.
- R10: Offset 4 stores and returns its value and has no effect on the outputs. Offsets above 8 read 0. With vectors not built in, offsets 7 and 8 read 0.
- R11: Reset clears status, enable, critical-select, polarity, trigger and vector configuration, so both outputs and the vector read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 32 | Interrupt source lines, already synchronous to clk |
| bus_wr_i | input | 1 | Register write strobe, one write per cycle |
| bus_addr_i | input | 4 | Register word offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Normal interrupt request |
| cirq_o | output | 1 | Critical interrupt request |

## Verification
The bench builds two copies on the same bus and source lines. The first uses the default width of 32 sources with the vector unit. The second is identical except that the vector unit is left out. The first copy covers the vector arithmetic in both scan directions, with two pending critical sources so that the direction actually changes the chosen index. The second copy covers the zero reads at the vector offsets when the unit is absent. Status tests mix level and edge sources in one register, so the reapply-on-clear behaviour is seen next to a cleared edge bit.

// File: rtl/crit_irq_pkg.sv
package crit_irq_pkg;
   localparam int BUS_AW = 4;

   typedef enum logic [BUS_AW-1:0] {
      OFF_STAT_CLR = 4'd0,
      OFF_STAT_SET = 4'd1,
      OFF_ENABLE   = 4'd2,
      OFF_CRIT     = 4'd3,
      OFF_POL      = 4'd4,
      OFF_TRIG     = 4'd5,
      OFF_MASKED   = 4'd6,
      OFF_VECTOR   = 4'd7,
      OFF_VCFG     = 4'd8
   } reg_off_e;
endpackage

// File: rtl/crit_irq_status.sv
module crit_irq_status #(
   parameter int N_SRC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_i,
   input  logic [N_SRC-1:0] trig_i,
   input  logic             clr_wr_i,
   input  logic             set_wr_i,
   input  logic [N_SRC-1:0] wdata_i,
   output logic [N_SRC-1:0] status_o
);
   logic [N_SRC-1:0] line_s;   // inputs reordered into status order
   logic [N_SRC-1:0] line_q;   // registered copy for change detection
   logic [N_SRC-1:0] status_q;

   generate
      for (genvar j = 0; j < N_SRC; j++) begin : g_bit
         logic rise, fall, lvl, base, nxt;

         assign line_s[j] = irq_i[N_SRC-1-j];
         assign rise = line_s[j] & ~line_q[j];
         assign fall = ~line_s[j] & line_q[j];
         assign lvl  = line_q[j] & ~trig_i[j];

         always_comb begin
            base = status_q[j];
            if (clr_wr_i)
               base = (status_q[j] & ~wdata_i[j]) | lvl;
            else if (set_wr_i)
               base = status_q[j] | wdata_i[j];
            if (trig_i[j])
               nxt = base | rise;
            else if (rise)
               nxt = 1'b1;
            else if (fall)
               nxt = 1'b0;
            else
               nxt = base;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               status_q[j] <= 1'b0;
               line_q[j]   <= 1'b0;
            end else begin
               status_q[j] <= nxt;
               line_q[j]   <= line_s[j];
            end
         end

         AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_i[j] && status_q[j] && !(clr_wr_i && wdata_i[j])) |=> status_q[j]); // R2
         AST_LVL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig_i[j] && line_s[j] && !line_q[j]) |=> status_q[j]); // R3
         AST_LVL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig_i[j] && !line_s[j] && line_q[j]) |=> !status_q[j]); // R3
      end
   endgenerate

   assign status_o = status_q;
endmodule

// File: rtl/crit_irq_vector.sv
module crit_irq_vector #(
   parameter int N_SRC     = 32,
   parameter int DATA_W    = 32,
   parameter int VEC_SHIFT = 9
) (
   input  logic [N_SRC-1:0]  crit_pend_i,
   input  logic [DATA_W-1:0] vcfg_i,
   output logic [DATA_W-1:0] vector_o
);
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   logic [IDX_W-1:0] idx;

   always_comb begin
      idx = '0;
      if (vcfg_i[0]) begin
         for (int i = 0; i < N_SRC; i++)
            if (crit_pend_i[i]) idx = IDX_W'(N_SRC - 1 - i);
      end else begin
         for (int i = N_SRC - 1; i >= 0; i--)
            if (crit_pend_i[i]) idx = IDX_W'(i);
      end
   end

   always_comb begin
      if (|crit_pend_i)
         vector_o = (vcfg_i & ~DATA_W'(3)) + (DATA_W'(idx) << VEC_SHIFT);
      else
         vector_o = '0;
   end
endmodule

// File: rtl/crit_irq_ctrl.sv
module crit_irq_ctrl
   import crit_irq_pkg::*;
#(
   parameter int N_SRC     = 32,
   parameter int DATA_W    = 32,
   parameter bit VEC_EN    = 1'b1,
   parameter int VEC_SHIFT = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_i,
   input  logic              bus_wr_i,
   input  logic [BUS_AW-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o,
   output logic              cirq_o
);
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   generate
      if (N_SRC < 1 || N_SRC > DATA_W) begin : g_bad_width
         $error("crit_irq_ctrl: N_SRC must be in 1..DATA_W");
      end
      if (VEC_EN && (VEC_SHIFT + IDX_W > DATA_W)) begin : g_bad_shift
         $error("crit_irq_ctrl: vector offset does not fit DATA_W");
      end
   endgenerate

   logic [N_SRC-1:0]  en_q, crit_q, pol_q, trig_q, status;
   logic [N_SRC-1:0]  wsrc;
   logic [DATA_W-1:0] vcfg, vector;
   logic              wr_clr, wr_set, wr_en, wr_crit, wr_pol, wr_trig, wr_vcfg;

   assign wsrc    = bus_wdata_i[N_SRC-1:0];
   assign wr_clr  = bus_wr_i && (bus_addr_i == OFF_STAT_CLR);
   assign wr_set  = bus_wr_i && (bus_addr_i == OFF_STAT_SET);
   assign wr_en   = bus_wr_i && (bus_addr_i == OFF_ENABLE);
   assign wr_crit = bus_wr_i && (bus_addr_i == OFF_CRIT);
   assign wr_pol  = bus_wr_i && (bus_addr_i == OFF_POL);
   assign wr_trig = bus_wr_i && (bus_addr_i == OFF_TRIG);
   assign wr_vcfg = bus_wr_i && (bus_addr_i == OFF_VCFG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         crit_q <= '0;
         pol_q  <= '0;
         trig_q <= '0;
      end else begin
         if (wr_en)   en_q   <= wsrc;
         if (wr_crit) crit_q <= wsrc;
         if (wr_pol)  pol_q  <= wsrc;
         if (wr_trig) trig_q <= wsrc;
      end
   end

   crit_irq_status #(.N_SRC(N_SRC)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_i    (irq_i),
      .trig_i   (trig_q),
      .clr_wr_i (wr_clr),
      .set_wr_i (wr_set),
      .wdata_i  (wsrc),
      .status_o (status)
   );

   logic [N_SRC-1:0] act, norm_pend, crit_pend;
   assign act       = status & en_q;
   assign norm_pend = act & ~crit_q;
   assign crit_pend = act & crit_q;
   assign irq_o     = |norm_pend;
   assign cirq_o    = |crit_pend;

   generate
      if (VEC_EN) begin : g_vec
         logic [DATA_W-1:0] vcfg_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               vcfg_q <= '0;
            else if (wr_vcfg)
               vcfg_q <= bus_wdata_i & ~DATA_W'(2);
         end
         assign vcfg = vcfg_q;

         crit_irq_vector #(
            .N_SRC     (N_SRC),
            .DATA_W    (DATA_W),
            .VEC_SHIFT (VEC_SHIFT)
         ) u_vector (
            .crit_pend_i (crit_pend),
            .vcfg_i      (vcfg_q),
            .vector_o    (vector)
         );
      end else begin : g_novec
         assign vcfg   = '0;
         assign vector = '0;
      end
   endgenerate

   always_comb begin
      case (bus_addr_i)
         OFF_STAT_CLR, OFF_STAT_SET: bus_rdata_o = DATA_W'(status);
         OFF_ENABLE:                 bus_rdata_o = DATA_W'(en_q);
         OFF_CRIT:                   bus_rdata_o = DATA_W'(crit_q);
         OFF_POL:                    bus_rdata_o = DATA_W'(pol_q);
         OFF_TRIG:                   bus_rdata_o = DATA_W'(trig_q);
         OFF_MASKED:                 bus_rdata_o = DATA_W'(act);
         OFF_VECTOR:                 bus_rdata_o = vector;
         OFF_VCFG:                   bus_rdata_o = vcfg;
         default:                    bus_rdata_o = '0;
      endcase
   end

   AST_EN_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_wdata_i == '0) |=> (!irq_o && !cirq_o)); // R7
   AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cirq_o |-> (vector == '0)); // R9
   AST_VCFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (VEC_EN && wr_vcfg) |=> (vcfg == ($past(bus_wdata_i) & ~DATA_W'(2)))); // R9
endmodule

// File: tb/test_crit_irq_ctrl.sv
module test_crit_irq_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata, rdata_nv;
   logic        irq, cirq, irq_nv, cirq_nv;

   always #(CLK_PERIOD/2) clk = ~clk;

   crit_irq_ctrl i_crit_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_in), .bus_wr_i(bus_wr),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata),
      .irq_o(irq), .cirq_o(cirq));

   crit_irq_ctrl #(.VEC_EN(1'b0)) i_crit_irq_ctrl_novec (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_in), .bus_wr_i(bus_wr),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata_nv),
      .irq_o(irq_nv), .cirq_o(cirq_nv));

   typedef struct {
      int          kind;   // 0 rdata, 1 irq, 2 cirq, 3 rdata without vectors
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sbq[$];
   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   // monitor: compares one expected item per falling edge
   always @(negedge clk) begin
      if (sbq.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sbq.pop_front();
         case (it.kind)
            0:       act = rdata;
            1:       act = {31'b0, irq};
            2:       act = {31'b0, cirq};
            default: act = rdata_nv;
         endcase
         n_run++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: kind %0d actual %08h expected %08h", it.tag, it.kind, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic expect_item(input int kind, input logic [3:0] a,
                              input logic [31:0] e, input string t);
      item_t it;
      @(posedge clk); #1;
      bus_addr = a;
      it.kind = kind; it.exp = e; it.tag = t;
      sbq.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
      expect_item(0, a, e, t);
   endtask

   task automatic set_in(input int n, input logic v);
      @(posedge clk); #1;
      irq_in[n] = v;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11: reset state
      rd(4'd0, 32'h0, "R11");
      rd(4'd2, 32'h0, "R11");
      rd(4'd8, 32'h0, "R11");
      rd(4'd7, 32'h0, "R11");
      expect_item(1, 4'd0, 32'h0, "R11");
      expect_item(2, 4'd0, 32'h0, "R11");

      // R1 / R3: level source on line 0 lands in bit 31
      set_in(0, 1'b1);
      rd(4'd0, 32'h8000_0000, "R1");
      rd(4'd1, 32'h8000_0000, "R5");
      set_in(0, 1'b0);
      rd(4'd0, 32'h0, "R3");

      // R2: edge source on line 31 (status bit 0) holds after the pulse
      wr(4'd5, 32'h0000_0001);
      rd(4'd5, 32'h0000_0001, "R2");
      set_in(31, 1'b1);
      set_in(31, 1'b0);
      rd(4'd0, 32'h0000_0001, "R2");
      wr(4'd0, 32'h0000_0001);
      rd(4'd0, 32'h0, "R4");

      // R4: clearing a level bit whose line is still high has no effect
      set_in(0, 1'b1);
      rd(4'd0, 32'h8000_0000, "R3");
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, 32'h8000_0000, "R4");

      // R5: software set
      wr(4'd1, 32'h0000_0F00);
      rd(4'd0, 32'h8000_0F00, "R5");

      // R6 / R7: masking and output split
      wr(4'd2, 32'h0000_0300);
      rd(4'd6, 32'h0000_0300, "R6");
      expect_item(1, 4'd6, 32'h1, "R7");
      expect_item(2, 4'd6, 32'h0, "R7");
      wr(4'd3, 32'h0000_0300);
      expect_item(1, 4'd3, 32'h0, "R7");
      expect_item(2, 4'd3, 32'h1, "R7");
      wr(4'd2, 32'h8000_0300);
      expect_item(1, 4'd2, 32'h1, "R7");
      expect_item(2, 4'd2, 32'h1, "R7");

      // R8 / R9: vector with two pending critical bits (8 and 9)
      wr(4'd8, 32'h0001_0003);
      rd(4'd8, 32'h0001_0001, "R9");
      rd(4'd7, 32'h0001_2C00, "R8");   // scan down: 31-9 = 22
      wr(4'd8, 32'h0001_0000);
      rd(4'd7, 32'h0001_1000, "R8");   // scan up: bit 8

      // R6: writes to offsets 6 and 7 ignored
      wr(4'd6, 32'h0);
      wr(4'd7, 32'hFFFF_FFFF);
      rd(4'd6, 32'h8000_0300, "R6");
      rd(4'd7, 32'h0001_1000, "R6");

      // R9: no critical pending gives zero vector
      wr(4'd3, 32'h0);
      rd(4'd7, 32'h0, "R9");
      expect_item(2, 4'd7, 32'h0, "R9");

      // R10: polarity round trip, unmapped offset, missing vector unit
      wr(4'd4, 32'hA5A5_A5A5);
      rd(4'd4, 32'hA5A5_A5A5, "R10");
      expect_item(1, 4'd4, 32'h1, "R10");
      rd(4'd9, 32'h0, "R10");
      expect_item(3, 4'd8, 32'h0, "R10");
      expect_item(3, 4'd7, 32'h0, "R10");
      expect_item(3, 4'd6, 32'h8000_0300, "R10");

      @(posedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule